// File: doc/BRIEF.md
# GPIO Output Router

This block decides, for each of a parameterised number of pads (40 by default), which value the pad drives and whether its driver is enabled. Each pad has a selector. A selector with its top bit clear picks one of the peripheral output signals. A selector with its top bit set picks the pad's own bit in a software data register. Each pad also has configuration bits that do four things:

- invert the driven value;
- take the enable from a software enable register even when a peripheral is selected;
- invert the enable;
- switch the pad from push-pull to open-drain drive.

The software data register and the software enable register are each split into two groups: a low group of 32 pads and a high group holding the remaining pads. Each group has three write paths. A plain write replaces the group. A set mask ORs ones into it. A clear mask removes ones from it. Software can therefore change single bits without a read-modify-write sequence. The per-pad configuration, the peripheral signals and the selectors are plain inputs, held in a configuration register file next to this block. The two software registers are the only storage inside the block.

Top module: `gpio_out_router`

## Requirements
- R1: After a synchronous active-low reset, both software registers hold all zeros. With selector 256, no inversion and push-pull mode, every pad then shows pad_out = 0 and pad_oe = 0.
- R2: With selector s below 256, the pad value before inversion is periph_out[s].
- R3: With selector 256 or any value up to 511 (selector bit 8 set), the pad value before inversion is the pad's bit of the software data register.
- R4: The per-pad out_inv bit complements the pad value.
- R5: The enable before inversion is the pad's bit of the software enable register when selector bit 8 is set or the pad's oe_from_reg bit is 1. Otherwise it is periph_oe[s].
- R6: The per-pad oe_inv bit complements the routed enable. This inversion comes before the open-drain gating.
- R7: A plain write on one group replaces exactly that group's bits: the low group holds pads 0 to 31 and the high group holds pads 32 and up. The other group is unchanged.
- R8: Within one cycle, a group is updated in this order: plain write first, then the set mask ORs in, then the clear mask removes bits. A bit that is both set and cleared in the same cycle ends at 0.
- R9: In open-drain mode, pad_out is 0 and pad_oe equals the inverted-as-configured enable ANDed with the complement of the inverted-as-configured value.
- R10: A software register access shows at the pad outputs after the next rising clock edge, not before it. Selector, configuration and peripheral inputs reach the outputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dat_lo_wr | input | 1 | Plain write strobe, data register low group |
| dat_lo_wdata | input | LO_W | Write value, data low group |
| dat_lo_set | input | LO_W | Set mask, data low group |
| dat_lo_clr | input | LO_W | Clear mask, data low group |
| dat_hi_wr | input | 1 | Plain write strobe, data register high group |
| dat_hi_wdata | input | HI_W | Write value, data high group |
| dat_hi_set | input | HI_W | Set mask, data high group |
| dat_hi_clr | input | HI_W | Clear mask, data high group |
| oen_lo_wr | input | 1 | Plain write strobe, enable register low group |
| oen_lo_wdata | input | LO_W | Write value, enable low group |
| oen_lo_set | input | LO_W | Set mask, enable low group |
| oen_lo_clr | input | LO_W | Clear mask, enable low group |
| oen_hi_wr | input | 1 | Plain write strobe, enable register high group |
| oen_hi_wdata | input | HI_W | Write value, enable high group |
| oen_hi_set | input | HI_W | Set mask, enable high group |
| oen_hi_clr | input | HI_W | Clear mask, enable high group |
| pad_sel | input | NUM_PADS*SEL_W | Per-pad source selector; pad p uses bits [p*SEL_W +: SEL_W] |
| pad_out_inv | input | NUM_PADS | Per-pad value inversion |
| pad_oe_from_reg | input | NUM_PADS | Per-pad: take the enable from the software register |
| pad_oe_inv | input | NUM_PADS | Per-pad enable inversion |
| pad_open_drain | input | NUM_PADS | Per-pad open-drain mode |
| periph_out | input | NUM_SRC | Peripheral output signals |
| periph_oe | input | NUM_SRC | Peripheral output enables |
| pad_out | output | NUM_PADS | Value driven to each pad |
| pad_oe | output | NUM_PADS | Output enable for each pad |

## Verification
Routing results are combinational. The bench applies a selector, configuration and peripheral pattern, waits a few time units away from any clock edge, and compares every pad. Software register results are due one edge after the access. The bench drives an access just after a falling edge and samples once before the following rising edge, where the old value must still show. It samples again after that edge, where the new value is expected. The sweep walks all 16 configuration combinations and selectors across the full 9-bit range on every pad.

// File: rtl/gpio_rt_pkg.sv
// Package: shared per-pad control bundle for the GPIO output router.
// Assumes nothing beyond the fields listed here.
package gpio_rt_pkg;

    // Per-pad drive controls, apart from the source selector.
    typedef struct packed {
        logic out_inv;      // complement driven value
        logic oe_from_reg;  // enable from software register
        logic oe_inv;       // complement enable
        logic open_drain;   // open-drain drive mode
    } pad_ctl_t;

endpackage

// File: rtl/gpio_sw_reg.sv
// Module: software register with two write groups, each taking a plain
// write, a set mask and a clear mask in the same cycle.
// Within a cycle the order is write, then set, then clear, so clear wins.
// Assumes HI_W >= 1.
module gpio_sw_reg #(
    parameter  int LO_W = 32,
    parameter  int HI_W = 8,
    localparam int W    = LO_W + HI_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lo_wr,
    input  logic [LO_W-1:0] lo_wdata,
    input  logic [LO_W-1:0] lo_set,
    input  logic [LO_W-1:0] lo_clr,
    input  logic            hi_wr,
    input  logic [HI_W-1:0] hi_wdata,
    input  logic [HI_W-1:0] hi_set,
    input  logic [HI_W-1:0] hi_clr,
    output logic [W-1:0]    q
);

    logic [LO_W-1:0] lo_nxt;
    logic [HI_W-1:0] hi_nxt;

    // Next value of each group: write, then set, then clear.
    always_comb begin
        lo_nxt = lo_wr ? lo_wdata : q[LO_W-1:0];
        lo_nxt = (lo_nxt | lo_set) & ~lo_clr;
        hi_nxt = hi_wr ? hi_wdata : q[W-1:LO_W];
        hi_nxt = (hi_nxt | hi_set) & ~hi_clr;
    end

    // State register, synchronous active-low reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= {hi_nxt, lo_nxt};
    end

    // R8
    lo_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|lo_clr) |=> ((q[LO_W-1:0] & $past(lo_clr)) == '0));
    // R8
    hi_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hi_clr) |=> ((q[W-1:LO_W] & $past(hi_clr)) == '0));
    // R8
    lo_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(lo_set & ~lo_clr)) |=>
        ((q[LO_W-1:0] & $past(lo_set & ~lo_clr)) == $past(lo_set & ~lo_clr)));
    // R7
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_wr && lo_set == '0 && lo_clr == '0) |=> $stable(q[LO_W-1:0]));
    // R7
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_wr && hi_set == '0 && hi_clr == '0) |=> $stable(q[W-1:LO_W]));

endmodule

// File: rtl/gpio_pad_route.sv
// Module: routing and drive stage for one pad.
// Picks the value and the enable from a peripheral or from the software
// registers, applies the two inversions, then the open-drain gating.
// Assumes the peripheral count equals 2**(SEL_W-1), so every selector
// with the top bit clear names a real source.
module gpio_pad_route
    import gpio_rt_pkg::*;
#(
    parameter  int SEL_W   = 9,
    localparam int IDX_W   = SEL_W - 1,
    localparam int NUM_SRC = 1 << IDX_W
) (
    input  logic [SEL_W-1:0]   sel,
    input  pad_ctl_t           ctl,
    input  logic [NUM_SRC-1:0] periph_out,
    input  logic [NUM_SRC-1:0] periph_oe,
    input  logic               sw_data,
    input  logic               sw_en,
    output logic               pad_out,
    output logic               pad_oe
);

    logic             use_sw;
    logic [IDX_W-1:0] idx;
    logic             val_raw, oe_raw, val, oe;

    // Source selection for the value and the enable.
    always_comb begin
        use_sw  = sel[SEL_W-1];
        idx     = sel[IDX_W-1:0];
        val_raw = use_sw ? sw_data : periph_out[idx];
        oe_raw  = (use_sw || ctl.oe_from_reg) ? sw_en : periph_oe[idx];
    end

    // Inversion, then push-pull or open-drain drive.
    always_comb begin
        val = val_raw ^ ctl.out_inv;
        oe  = oe_raw ^ ctl.oe_inv;
        if (ctl.open_drain) begin
            pad_out = 1'b0;
            pad_oe  = oe & ~val;
        end else begin
            pad_out = val;
            pad_oe  = oe;
        end
    end

endmodule

// File: rtl/gpio_out_router.sv
// Module: top of the GPIO output router.
// Holds the software data and enable registers and one routing stage per
// pad. Per-pad controls arrive flat and are unpacked here.
// Assumes NUM_PADS > LO_W.
module gpio_out_router
    import gpio_rt_pkg::*;
#(
    parameter  int NUM_PADS = 40,
    parameter  int SEL_W    = 9,
    parameter  int LO_W     = 32,
    localparam int HI_W     = NUM_PADS - LO_W,
    localparam int NUM_SRC  = 1 << (SEL_W - 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dat_lo_wr,
    input  logic [LO_W-1:0]           dat_lo_wdata,
    input  logic [LO_W-1:0]           dat_lo_set,
    input  logic [LO_W-1:0]           dat_lo_clr,
    input  logic                      dat_hi_wr,
    input  logic [HI_W-1:0]           dat_hi_wdata,
    input  logic [HI_W-1:0]           dat_hi_set,
    input  logic [HI_W-1:0]           dat_hi_clr,
    input  logic                      oen_lo_wr,
    input  logic [LO_W-1:0]           oen_lo_wdata,
    input  logic [LO_W-1:0]           oen_lo_set,
    input  logic [LO_W-1:0]           oen_lo_clr,
    input  logic                      oen_hi_wr,
    input  logic [HI_W-1:0]           oen_hi_wdata,
    input  logic [HI_W-1:0]           oen_hi_set,
    input  logic [HI_W-1:0]           oen_hi_clr,
    input  logic [NUM_PADS*SEL_W-1:0] pad_sel,
    input  logic [NUM_PADS-1:0]       pad_out_inv,
    input  logic [NUM_PADS-1:0]       pad_oe_from_reg,
    input  logic [NUM_PADS-1:0]       pad_oe_inv,
    input  logic [NUM_PADS-1:0]       pad_open_drain,
    input  logic [NUM_SRC-1:0]        periph_out,
    input  logic [NUM_SRC-1:0]        periph_oe,
    output logic [NUM_PADS-1:0]       pad_out,
    output logic [NUM_PADS-1:0]       pad_oe
);

    logic [NUM_PADS-1:0] sw_data_q;
    logic [NUM_PADS-1:0] sw_en_q;

    gpio_sw_reg #(.LO_W(LO_W), .HI_W(HI_W)) u_data_reg (
        .clk(clk), .rst_n(rst_n),
        .lo_wr(dat_lo_wr), .lo_wdata(dat_lo_wdata),
        .lo_set(dat_lo_set), .lo_clr(dat_lo_clr),
        .hi_wr(dat_hi_wr), .hi_wdata(dat_hi_wdata),
        .hi_set(dat_hi_set), .hi_clr(dat_hi_clr),
        .q(sw_data_q)
    );

    gpio_sw_reg #(.LO_W(LO_W), .HI_W(HI_W)) u_en_reg (
        .clk(clk), .rst_n(rst_n),
        .lo_wr(oen_lo_wr), .lo_wdata(oen_lo_wdata),
        .lo_set(oen_lo_set), .lo_clr(oen_lo_clr),
        .hi_wr(oen_hi_wr), .hi_wdata(oen_hi_wdata),
        .hi_set(oen_hi_set), .hi_clr(oen_hi_clr),
        .q(sw_en_q)
    );

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        pad_ctl_t         ctl;
        logic [SEL_W-1:0] sel;

        // Unpack this pad's flat controls.
        always_comb begin
            sel             = pad_sel[p*SEL_W +: SEL_W];
            ctl.out_inv     = pad_out_inv[p];
            ctl.oe_from_reg = pad_oe_from_reg[p];
            ctl.oe_inv      = pad_oe_inv[p];
            ctl.open_drain  = pad_open_drain[p];
        end

        gpio_pad_route #(.SEL_W(SEL_W)) u_route (
            .sel(sel), .ctl(ctl),
            .periph_out(periph_out), .periph_oe(periph_oe),
            .sw_data(sw_data_q[p]), .sw_en(sw_en_q[p]),
            .pad_out(pad_out[p]), .pad_oe(pad_oe[p])
        );

        // R9
        od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pad_open_drain[p] |-> !pad_out[p]);
        // R3
        sw_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[SEL_W-1] && !pad_out_inv[p] && !pad_open_drain[p])
            |-> (pad_out[p] == sw_data_q[p]));
        // R5
        sw_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((sel[SEL_W-1] || pad_oe_from_reg[p]) && !pad_oe_inv[p] && !pad_open_drain[p])
            |-> (pad_oe[p] == sw_en_q[p]));
        // R2
        periph_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel[SEL_W-1] && !pad_out_inv[p] && !pad_open_drain[p])
            |-> (pad_out[p] == periph_out[sel[SEL_W-2:0]]));
    end

endmodule

// File: tb/tb_gpio_out_router.sv
module tb_gpio_out_router;
    localparam int CLK_P = 10;
    localparam int NP    = 40;
    localparam int SW    = 9;
    localparam int NS    = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic        dat_lo_wr = 0, dat_hi_wr = 0, oen_lo_wr = 0, oen_hi_wr = 0;
    logic [31:0] dat_lo_wdata = 0, dat_lo_set = 0, dat_lo_clr = 0;
    logic [31:0] oen_lo_wdata = 0, oen_lo_set = 0, oen_lo_clr = 0;
    logic [7:0]  dat_hi_wdata = 0, dat_hi_set = 0, dat_hi_clr = 0;
    logic [7:0]  oen_hi_wdata = 0, oen_hi_set = 0, oen_hi_clr = 0;
    logic [NP*SW-1:0] pad_sel;
    logic [NP-1:0] pad_out_inv = 0, pad_oe_from_reg = 0, pad_oe_inv = 0, pad_open_drain = 0;
    logic [NS-1:0] periph_out = 0, periph_oe = 0;
    logic [NP-1:0] pad_out, pad_oe;

    logic [NP-1:0] m_data = 0, m_en = 0;
    int n_chk = 0, n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio_out_router dut (
        .clk(clk), .rst_n(rst_n),
        .dat_lo_wr(dat_lo_wr), .dat_lo_wdata(dat_lo_wdata), .dat_lo_set(dat_lo_set), .dat_lo_clr(dat_lo_clr),
        .dat_hi_wr(dat_hi_wr), .dat_hi_wdata(dat_hi_wdata), .dat_hi_set(dat_hi_set), .dat_hi_clr(dat_hi_clr),
        .oen_lo_wr(oen_lo_wr), .oen_lo_wdata(oen_lo_wdata), .oen_lo_set(oen_lo_set), .oen_lo_clr(oen_lo_clr),
        .oen_hi_wr(oen_hi_wr), .oen_hi_wdata(oen_hi_wdata), .oen_hi_set(oen_hi_set), .oen_hi_clr(oen_hi_clr),
        .pad_sel(pad_sel), .pad_out_inv(pad_out_inv), .pad_oe_from_reg(pad_oe_from_reg),
        .pad_oe_inv(pad_oe_inv), .pad_open_drain(pad_open_drain),
        .periph_out(periph_out), .periph_oe(periph_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Expected {out, oe} of one pad, from the requirements.
    function automatic logic [1:0] expect_pad(input int p);
        int  s;
        logic v, e;
        s = int'(pad_sel[p*SW +: SW]);
        if (s >= 256) begin
            v = m_data[p];
            e = m_en[p];
        end else begin
            v = periph_out[s];
            e = pad_oe_from_reg[p] ? m_en[p] : periph_oe[s];
        end
        v = v ^ pad_out_inv[p];
        e = e ^ pad_oe_inv[p];
        if (pad_open_drain[p]) return {1'b0, e & ~v};
        return {v, e};
    endfunction

    task automatic check_all(input string tag);
        for (int p = 0; p < NP; p++) begin
            logic [1:0] exp_v;
            exp_v = expect_pad(p);
            n_chk++;
            if ({pad_out[p], pad_oe[p]} !== exp_v) begin
                n_bad++;
                $display("FAIL %s pad %0d sel %0d: got out/oe=%b expected %b",
                         tag, p, pad_sel[p*SW +: SW], {pad_out[p], pad_oe[p]}, exp_v);
            end
        end
    endtask

    // One register access, driven after a falling edge; the model follows after the rising edge.
    task automatic reg_op(input bit is_en, input bit lwr, input logic [31:0] lwd, lset, lclr,
                          input bit hwr, input logic [7:0] hwd, hset, hclr, input string tag);
        logic [NP-1:0] nxt, cur;
        logic [31:0] lo;
        logic [7:0]  hi;
        cur = is_en ? m_en : m_data;
        lo = lwr ? lwd : cur[31:0];
        lo = (lo | lset) & ~lclr;
        hi = hwr ? hwd : cur[39:32];
        hi = (hi | hset) & ~hclr;
        nxt = {hi, lo};
        if (is_en) begin
            oen_lo_wr = lwr; oen_lo_wdata = lwd; oen_lo_set = lset; oen_lo_clr = lclr;
            oen_hi_wr = hwr; oen_hi_wdata = hwd; oen_hi_set = hset; oen_hi_clr = hclr;
        end else begin
            dat_lo_wr = lwr; dat_lo_wdata = lwd; dat_lo_set = lset; dat_lo_clr = lclr;
            dat_hi_wr = hwr; dat_hi_wdata = hwd; dat_hi_set = hset; dat_hi_clr = hclr;
        end
        #1;
        check_all("R10 before edge");
        @(posedge clk);
        @(negedge clk);
        dat_lo_wr = 0; dat_lo_set = 0; dat_lo_clr = 0; dat_hi_wr = 0; dat_hi_set = 0; dat_hi_clr = 0;
        oen_lo_wr = 0; oen_lo_set = 0; oen_lo_clr = 0; oen_hi_wr = 0; oen_hi_set = 0; oen_hi_clr = 0;
        if (is_en) m_en = nxt; else m_data = nxt;
        #1;
        check_all(tag);
    endtask

    function automatic logic pat(input int k, input int i);
        return ((i * (2 * k + 3) + k * 5 + (i >> 3)) % 7) < 3;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) pad_sel[p*SW +: SW] = 9'd256;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_all("R1 reset");

        // Data and enable writes, each group on its own.
        reg_op(0, 1, 32'hA5A5_1234, 0, 0, 0, 0, 0, 0, "R3 R7 data lo write");
        reg_op(0, 0, 0, 0, 0, 1, 8'h3C, 0, 0, "R3 R7 data hi write");
        reg_op(1, 1, 32'hFFFF_0000, 0, 0, 1, 8'hC3, 0, 0, "R5 R7 enable write");
        reg_op(0, 1, 32'h0F0F_0F0F, 0, 0, 0, 0, 0, 0, "R7 lo write leaves hi");
        reg_op(0, 0, 0, 32'h0000_00F0, 32'h0000_0030, 0, 0, 8'h81, 8'h01, "R8 set clear clear wins");
        reg_op(1, 1, 32'h1234_5678, 32'h0000_0001, 32'h0000_0008, 1, 8'h10, 8'h06, 8'h14, "R8 write set clear order");
        reg_op(1, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 8'hFF, 0, "R8 full overlap clear wins");

        // Sweep of selectors and configuration combinations.
        for (int k = 0; k < 48; k++) begin
            for (int p = 0; p < NP; p++) begin
                int c;
                pad_sel[p*SW +: SW] = 9'((p * 37 + k * 53 + 11) % 512);
                c = (p * 3 + k) % 16;
                pad_out_inv[p]     = c[0];
                pad_oe_from_reg[p] = c[1];
                pad_oe_inv[p]      = c[2];
                pad_open_drain[p]  = c[3];
            end
            for (int i = 0; i < NS; i++) begin
                periph_out[i] = pat(k, i);
                periph_oe[i]  = pat(k + 77, i);
            end
            #2;
            check_all("R2 R3 R4 R5 R6 R9 sweep");
            if (k == 20) begin
                @(negedge clk);
                reg_op(0, 1, 32'h5A5A_C3C3, 0, 0, 1, 8'h96, 0, 0, "R3 R10 write under mixed config");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule